// File: doc/BRIEF.md
# Page Write Buffer and Sequencer

This block sits behind the serial command decoder of a byte-addressed serial memory. It handles the array write command. When the decoder has received the opcode and the start address, it pulses a start strobe. If writes are enabled and the target page is not locked, the sequencer then collects the data bytes that follow into a page-sized staging buffer. The column pointer wraps inside the page, so a byte sent after the last column of the page overwrites the first one. A per-byte valid mask records which columns were actually received.

The sequencer decides when chip select rises. The write commits only if at least one byte was received and no bits of a following byte had been shifted in. Any other chip-select rise discards the whole command.

A committed write starts a self-timed internal cycle, and the busy flag stays high for all of it. The cycle has two parts:
- a copy sweep that visits every column of the page once and writes only the received bytes to the array;
- a hold period whose length is a parameter in system clocks.

In the last cycle of the hold period the block pulses a request that clears the write enable latch. Busy then falls. While busy is high the block ignores new start strobes and data bytes.

The FSM has four states: ST_IDLE, ST_FILL, ST_COPY and ST_HOLD. Its transitions are:
- ST_IDLE to ST_FILL on an accepted start strobe.
- ST_FILL to ST_COPY on an aligned commit.
- ST_FILL to ST_IDLE on a discarded chip-select rise.
- ST_COPY to ST_HOLD after the last column.
- ST_HOLD to ST_IDLE at the end of the hold count.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, busy, arr_we and wel_clr are all 0.
- R2: A start strobe is ignored when wel is 0 or page_prot is 1. The bytes and chip-select rise that follow then produce no busy period and no array write.
- R3: Data bytes are buffered at consecutive columns. The first byte goes to the column given by the low log2(PAGE_BYTES) bits of wr_addr. After column PAGE_BYTES-1 the pointer returns to column 0 of the same page, and a later byte replaces an earlier byte in the same column.
- R4: A cs_rise in ST_FILL with bit_partial at 0 and at least one byte received commits the write. busy reads 1 from the clock after the commit edge.
- R5: A cs_rise with bit_partial at 1, or with no byte received, discards the command. No busy period and no array write follow.
- R6: After a commit, the block spends PAGE_BYTES cycles on the copy sweep, visiting columns 0 to PAGE_BYTES-1 in ascending order. In each cycle arr_we is 1 only if that column was received. arr_addr is {page of wr_addr, column}, and arr_wdata is the last byte buffered for that column.
- R7: busy stays 1 for exactly PAGE_BYTES + WC_CYCLES consecutive cycles per committed write.
- R8: wel_clr is 1 for exactly one cycle, the last cycle of the busy period. busy is 0 in the following cycle.
- R9: While busy is 1, start strobes and byte strobes have no effect on the writes in progress, and no new write follows from them.
- R10: A byte strobe in the same cycle as the committing cs_rise is included in the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Write opcode and address received |
| wr_addr | input | ADDR_W | Start byte address of the write |
| byte_stb | input | 1 | One data byte completed |
| byte_data | input | DATA_W | Completed data byte |
| cs_rise | input | 1 | Chip select rose this cycle |
| bit_partial | input | 1 | Bits of an unfinished byte are pending |
| wel | input | 1 | Write enable latch state |
| page_prot | input | 1 | Start address lies in a locked region |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| wel_clr | output | 1 | Request to clear the write enable latch |

## Verification
Two things can land in the same clock: the final data byte strobe and the chip-select rise that commits the write. The bench drives both in one cycle, both with bit_partial low and with bit_partial high. It then judges from the copy sweep whether that byte reached the array and whether the write committed at all.

A second case overlaps a new start strobe and new bytes with the copy and hold phases. For that case the bench confirms that the array stream and the busy length match those of the original write.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_COPY,
        ST_HOLD
    } pg_state_t;
endpackage

// File: rtl/pgwr_count.sv
module pgwr_count #(
    parameter int LIMIT = 32,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          last
);
    assign last = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en)
            cnt <= last ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int COL_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [COL_W-1:0]  wcol,
    input  logic [DATA_W-1:0] wdata,
    input  logic [COL_W-1:0]  rcol,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              any_valid
);
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vmask_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic hit;
        assign hit = wr && (wcol == COL_W'(g));

        always_ff @(posedge clk) begin
            if (hit)
                slot_q[g] <= wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vmask_q[g] <= 1'b0;
            else if (clr)
                vmask_q[g] <= 1'b0;
            else if (hit)
                vmask_q[g] <= 1'b1;
        end
    end

    assign rdata     = slot_q[rcol];
    assign rvalid    = vmask_q[rcol];
    assign any_valid = |vmask_q;
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int WC_CYCLES  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              bit_partial,
    input  logic              wel,
    input  logic              page_prot,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              wel_clr
);
    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - COL_W;
    localparam int HOLD_W = $clog2(WC_CYCLES + 1);

    pg_state_t          state_q, state_d;
    logic [PAGE_W-1:0]  page_q;
    logic [COL_W-1:0]   col_q;
    logic               start_ok, fill_wr, commit_ok;
    logic [COL_W-1:0]   cp_cnt;
    logic               cp_last;
    logic [HOLD_W-1:0]  hd_cnt;
    logic               hd_last;
    logic [DATA_W-1:0]  rd_data;
    logic               rd_valid, any_valid;

    assign start_ok  = (state_q == ST_IDLE) && wr_start && wel && !page_prot;
    assign fill_wr   = (state_q == ST_FILL) && byte_stb;
    assign commit_ok = !bit_partial && (any_valid || byte_stb);

    pgwr_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .wr(fill_wr), .wcol(col_q),
        .wdata(byte_data), .rcol(cp_cnt), .rdata(rd_data), .rvalid(rd_valid),
        .any_valid(any_valid)
    );

    pgwr_count #(.LIMIT(PAGE_BYTES), .CW(COL_W)) u_cp_cnt (
        .clk(clk), .rst_n(rst_n), .clr(state_q != ST_COPY),
        .en(state_q == ST_COPY), .cnt(cp_cnt), .last(cp_last)
    );

    pgwr_count #(.LIMIT(WC_CYCLES), .CW(HOLD_W)) u_hd_cnt (
        .clk(clk), .rst_n(rst_n), .clr(state_q != ST_HOLD),
        .en(state_q == ST_HOLD), .cnt(hd_cnt), .last(hd_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_FILL;
            ST_FILL: if (cs_rise)  state_d = commit_ok ? ST_COPY : ST_IDLE;
            ST_COPY: if (cp_last)  state_d = ST_HOLD;
            ST_HOLD: if (hd_last)  state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // Page and in-page column pointer (wraps inside the page)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            col_q  <= '0;
        end else if (start_ok) begin
            page_q <= wr_addr[ADDR_W-1:COL_W];
            col_q  <= wr_addr[COL_W-1:0];
        end else if (fill_wr) begin
            col_q  <= (col_q == COL_W'(PAGE_BYTES - 1)) ? '0 : col_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q == ST_COPY) || (state_q == ST_HOLD);
        arr_we    = (state_q == ST_COPY) && rd_valid;
        arr_addr  = {page_q, cp_cnt};
        arr_wdata = rd_data;
        wel_clr   = (state_q == ST_HOLD) && hd_last;
    end

    a_r6_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    a_r8_clr_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !busy);
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wel_clr) |=> busy);
    a_r10_same_cycle_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cs_rise && !bit_partial && byte_stb) |=> busy);
    a_r5_partial_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cs_rise && bit_partial) |=> !busy);
    a_r9_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_start) |=> $stable(page_q));
endmodule

// File: tb/pgwr_seq_tb.sv
`timescale 1ns/1ps
module pgwr_seq_tb_top;
    localparam int AW = 11;
    localparam int PB = 32;
    localparam int WC = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_start = 0;
    logic [AW-1:0] wr_addr = '0;
    logic          byte_stb = 0;
    logic [7:0]    byte_data = '0;
    logic          cs_rise = 0;
    logic          bit_partial = 0;
    logic          wel = 1;
    logic          page_prot = 0;
    logic          busy, arr_we, wel_clr;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    int busy_len = 0;
    int last_busy_len = 0;

    always #2.5 clk = ~clk;

    pgwr_seq #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(PB), .WC_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .cs_rise(cs_rise),
        .bit_partial(bit_partial), .wel(wel), .page_prot(page_prot),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .wel_clr(wel_clr)
    );

    // Behavioural reference model
    int   m_mode = 0;
    int   m_k = 0;
    int   m_page = 0;
    int   m_col = 0;
    int   m_buf [PB];
    bit   m_val [PB];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit any;
        if (!rst_n) m_mode = 0;
        else case (m_mode)
            0: if (wr_start && wel && !page_prot) begin
                   m_mode = 1; m_page = int'(wr_addr) / PB; m_col = int'(wr_addr) % PB;
                   foreach (m_val[i]) m_val[i] = 0;
               end
            1: begin
                   if (byte_stb) begin
                       m_buf[m_col] = int'(byte_data); m_val[m_col] = 1;
                       m_col = (m_col + 1) % PB;
                   end
                   if (cs_rise) begin
                       any = 0;
                       foreach (m_val[i]) any |= m_val[i];
                       m_mode = (!bit_partial && any) ? 2 : 0;
                       m_k = 0;
                   end
               end
            default: begin
                   m_k++;
                   if (m_k == PB + WC) m_mode = 0;
               end
        endcase
        #1;
        if (arr_we) wr_seen++;
        if (busy) busy_len++;
        else if (busy_len != 0) begin last_busy_len = busy_len; busy_len = 0; end
        chk("R7 busy", int'(busy), int'(m_mode == 2));
        chk("R6 arr_we", int'(arr_we), int'(m_mode == 2 && m_k < PB && m_val[m_k % PB]));
        if (m_mode == 2 && m_k < PB && m_val[m_k]) begin
            chk("R6 arr_addr", int'(arr_addr), m_page * PB + m_k);
            chk("R3 arr_wdata", int'(arr_wdata), m_buf[m_k]);
        end
        chk("R8 wel_clr", int'(wel_clr), int'(m_mode == 2 && m_k == PB + WC - 1));
    end

    task automatic start(input int a);
        @(negedge clk); wr_start = 1; wr_addr = AW'(a);
        @(negedge clk); wr_start = 0;
    endtask
    task automatic send(input int d, input bit up, input bit part);
        @(negedge clk); byte_stb = 1; byte_data = 8'(d); cs_rise = up; bit_partial = part;
        @(negedge clk); byte_stb = 0; cs_rise = 0; bit_partial = 0;
    endtask
    task automatic rise(input bit part);
        @(negedge clk); cs_rise = 1; bit_partial = part;
        @(negedge clk); cs_rise = 0; bit_partial = 0;
    endtask
    task automatic settle();
        repeat (PB + WC + 6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 arr_we", int'(arr_we), 0);
        chk("R1 wel_clr", int'(wel_clr), 0);
        rst_n = 1;

        // R2: latch clear, then locked page
        wr_seen = 0; wel = 0; start(16'h010); send(8'h11, 0, 0); rise(0); settle(); wel = 1;
        chk("R2 wel off writes", wr_seen, 0);
        wr_seen = 0; page_prot = 1; start(16'h600); send(8'h22, 0, 0); rise(0); settle(); page_prot = 0;
        chk("R2 locked writes", wr_seen, 0);

        // R4: single byte
        wr_seen = 0; start(16'h123); send(8'hA5, 0, 0); rise(0); settle();
        chk("R4 single byte writes", wr_seen, 1);
        chk("R7 busy length", last_busy_len, PB + WC);

        // R3: wrap from column 30
        wr_seen = 0; start(16'h03E); send(8'h01, 0, 0); send(8'h02, 0, 0); send(8'h03, 0, 0);
        rise(0); settle();
        chk("R3 wrap writes", wr_seen, 3);

        // R3: overwrite, 34 bytes from column 5
        wr_seen = 0; start(16'h2A5);
        for (int i = 0; i < 34; i++) send(i + 8'h40, 0, 0);
        rise(0); settle();
        chk("R3 overwrite writes", wr_seen, PB);

        // R5: partial bits, then no bytes
        wr_seen = 0; start(16'h100); send(8'h77, 0, 0); send(8'h78, 0, 0); rise(1); settle();
        chk("R5 partial writes", wr_seen, 0);
        wr_seen = 0; start(16'h100); rise(0); settle();
        chk("R5 empty writes", wr_seen, 0);

        // R10: byte and CS rise together, aligned and misaligned
        wr_seen = 0; start(16'h444); send(8'h5A, 0, 0); send(8'hC3, 1, 0); settle();
        chk("R10 same cycle writes", wr_seen, 2);
        wr_seen = 0; start(16'h444); send(8'h5A, 1, 1); settle();
        chk("R10 misaligned writes", wr_seen, 0);

        // R9: activity during busy
        wr_seen = 0; start(16'h7E0); send(8'h99, 1, 0);
        repeat (5) @(negedge clk);
        start(16'h000); send(8'h10, 0, 0); send(8'h11, 1, 0);
        repeat (PB) @(negedge clk);
        send(8'h12, 1, 0);
        settle();
        chk("R9 busy ignore writes", wr_seen, 1);
        chk("R9 busy length", last_busy_len, PB + WC);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule